// File: doc/BRIEF.md
# Quadrature Bus Strobe Generator

This block sits between an 8-bit bus master and its peripherals and supplies the bus timing. From a fast input clock it makes two square phases that run a quarter cycle apart. Each phase is high for two input clocks out of a four-clock bus cycle, and the `q_ph` phase leads `e_ph` by one clock. From these phases and the master's read/write line it makes an address-valid qualifier and two active-low strobes. The read strobe spans the whole valid window. The write strobe follows only the leading phase, so that write data is held well after the strobe rises. The block also supplies the enable and the direction for the bidirectional data buffer.

A diagnostic mode, `kernel_mode`, exercises the address decoders. It floats the data buffer and holds both strobes idle. In place of the master's address it drives a free-running address counter, which advances once per bus cycle and wraps at the top of its range. With an 8 MHz input clock the bus cycle rate is 2 MHz.

Top module: `bus_strobe_gen`

## Requirements
- R1: A clock edge with `rst_n` low leaves `e_ph`, `q_ph` and `addr_valid` low, `rd_n` and `wr_n` high, and the sweep address at zero.
- R2: Count clock edges after reset release from 1. `q_ph` is high in cycles 1 and 2 of every four and `e_ph` is high in cycles 2 and 3, so `q_ph` leads by one clock.
- R3: `addr_valid` is high exactly when `q_ph` or `e_ph` is high.
- R4: In normal mode, with `rw`=1 meaning read, `rd_n` is low exactly while `addr_valid` is high.
- R5: In normal mode, with `rw`=0 meaning write, `wr_n` is low exactly while `q_ph` is high. This is cycles 1 and 2 of each bus cycle.
- R6: In normal mode `buf_en` is 1 and `buf_dir` equals `rw`, where 1 means data flows toward the master.
- R7: With `kernel_mode` high, `buf_en` is 0 and both `rd_n` and `wr_n` stay high in every phase, whatever `rw` is.
- R8: With `kernel_mode` high, `addr_out` starts at zero. It increments on the edge that ends each bus cycle, which is the edge leaving the state where only `e_ph` is high. It wraps from all ones to zero.
- R9: In normal mode `addr_out` equals `cpu_addr` in the same cycle, and the sweep counter is held at zero.
- R10: `rd_n` and `wr_n` are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, four per bus cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| rw | input | 1 | Master read/write line, 1 = read |
| kernel_mode | input | 1 | Diagnostic address-sweep mode |
| cpu_addr | input | ADDR_W | Master address |
| e_ph | output | 1 | Trailing bus phase |
| q_ph | output | 1 | Leading bus phase |
| addr_valid | output | 1 | Address-valid qualifier |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| buf_en | output | 1 | Data buffer enable, 1 = driving |
| buf_dir | output | 1 | Data buffer direction, 1 = toward master |
| addr_out | output | ADDR_W | Address to peripherals |

## Verification
The phases are registered, so they move one clock edge after reset release and one edge after each earlier phase state. The valid qualifier, the strobes and the buffer controls are combinational from those registers and the inputs, so a change on `rw` or `kernel_mode` shows up in the same cycle. The sweep address changes one edge after the E-only state. The bench changes inputs only on the falling clock, just before the edge that starts a bus cycle. It counts rising edges since reset release and samples every output on the next falling clock, so each sample is compared with the phase that the count predicts.

// File: rtl/bus_strobe_pkg.sv
// Shared types for the quadrature bus strobe generator.
// Assumes a four-clock bus cycle encoded in two phase flops.
package bus_strobe_pkg;
    typedef struct packed {
        logic q;  // leading phase
        logic e;  // trailing phase
    } phase_t;

    localparam phase_t PHASE_IDLE = '{q: 1'b0, e: 1'b0};
endpackage

// File: rtl/bsg_phase_gen.sv
// Two-flop twisted-ring counter that produces the leading and trailing
// bus phases. Sequence of {q,e}: 00 -> 10 -> 11 -> 01 -> 00.
// Assumes a synchronous active-low reset.
module bsg_phase_gen
    import bus_strobe_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_t phase,
    output logic   end_of_cycle
);
    phase_t ph_r;

    // Advance the ring by one step per input clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_r <= PHASE_IDLE;
        end else begin
            ph_r.q <= ~ph_r.e;
            ph_r.e <= ph_r.q;
        end
    end

    // Flag the last state of the bus cycle, where only the trailing phase is high.
    always_comb begin
        end_of_cycle = ph_r.e & ~ph_r.q;
    end

    assign phase = ph_r;
endmodule

// File: rtl/bsg_strobe_decode.sv
// Combines the bus phases with the read/write line to form the valid
// qualifier, the read and write strobes and the data buffer controls.
// Assumes the phases come straight from flops, so the outputs are glitch-free.
module bsg_strobe_decode
    import bus_strobe_pkg::*;
(
    input  phase_t phase,
    input  logic   rw,
    input  logic   kernel_mode,
    output logic   addr_valid,
    output logic   rd_n,
    output logic   wr_n,
    output logic   buf_en,
    output logic   buf_dir
);
    logic normal;

    // Form the strobes. Writes use only the leading phase, which gives longer data hold.
    always_comb begin
        normal     = ~kernel_mode;
        addr_valid = phase.q | phase.e;
        rd_n       = ~(addr_valid & rw & normal);
        wr_n       = ~(phase.q & ~rw & normal);
    end

    // Buffer control: float in diagnostic mode, otherwise follow rw.
    always_comb begin
        buf_en  = normal;
        buf_dir = rw;
    end
endmodule

// File: rtl/bsg_addr_sweep.sv
// Diagnostic address counter and the output address mux.
// Assumes end_of_cycle is high for exactly one clock per bus cycle.
module bsg_addr_sweep #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kernel_mode,
    input  logic              end_of_cycle,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic [ADDR_W-1:0] addr_out
);
    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic [ADDR_W-1:0] sweep_r;

    // Count bus cycles while in diagnostic mode and stay at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !kernel_mode) begin
            sweep_r <= '0;
        end else if (end_of_cycle) begin
            sweep_r <= sweep_r + ONE;
        end
    end

    // Select the sweep counter or the master's address.
    always_comb begin
        addr_out = kernel_mode ? sweep_r : cpu_addr;
    end
endmodule

// File: rtl/bus_strobe_gen.sv
// Top level of the quadrature bus strobe generator: phase ring, strobe
// decode and diagnostic address sweep.
// Assumes rw and cpu_addr are stable from the start of each bus cycle.
module bus_strobe_gen
    import bus_strobe_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rw,
    input  logic              kernel_mode,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              e_ph,
    output logic              q_ph,
    output logic              addr_valid,
    output logic              rd_n,
    output logic              wr_n,
    output logic              buf_en,
    output logic              buf_dir,
    output logic [ADDR_W-1:0] addr_out
);
    phase_t phase;
    logic   end_of_cycle;

    bsg_phase_gen u_phase (
        .clk          (clk),
        .rst_n        (rst_n),
        .phase        (phase),
        .end_of_cycle (end_of_cycle)
    );

    bsg_strobe_decode u_decode (
        .phase       (phase),
        .rw          (rw),
        .kernel_mode (kernel_mode),
        .addr_valid  (addr_valid),
        .rd_n        (rd_n),
        .wr_n        (wr_n),
        .buf_en      (buf_en),
        .buf_dir     (buf_dir)
    );

    bsg_addr_sweep #(.ADDR_W(ADDR_W)) u_sweep (
        .clk          (clk),
        .rst_n        (rst_n),
        .kernel_mode  (kernel_mode),
        .end_of_cycle (end_of_cycle),
        .cpu_addr     (cpu_addr),
        .addr_out     (addr_out)
    );

    // Bring the phases out to the ports.
    always_comb begin
        q_ph = phase.q;
        e_ph = phase.e;
    end
endmodule

// File: rtl/bus_strobe_gen_chk.sv
// Checker for bus_strobe_gen: phase order, strobe timing, diagnostic mode
// and the sweep counter. Bound to every instance of the top module.
module bus_strobe_gen_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rw,
    input logic              kernel_mode,
    input logic              e_ph,
    input logic              q_ph,
    input logic              addr_valid,
    input logic              rd_n,
    input logic              wr_n,
    input logic              buf_en,
    input logic [ADDR_W-1:0] addr_out
);
    assert_q_leads_e_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q_ph && !e_ph) |=> (q_ph && e_ph));

    assert_e_trails_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_ph && e_ph) |=> (!q_ph && !e_ph));

    assert_valid_opens_with_q_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_valid) |-> $rose(q_ph));

    assert_read_needs_rw_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> (rw && addr_valid && !kernel_mode));

    assert_write_in_q_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> (q_ph && !kernel_mode));

    assert_kernel_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        kernel_mode |-> (rd_n && wr_n && !buf_en));

    assert_sweep_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (kernel_mode && $past(kernel_mode) && $past(e_ph && !q_ph))
        |-> (addr_out == ADDR_W'($past(addr_out) + 1'b1)));

    assert_strobes_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (rd_n || wr_n));
endmodule

bind bus_strobe_gen bus_strobe_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rw          (rw),
    .kernel_mode (kernel_mode),
    .e_ph        (e_ph),
    .q_ph        (q_ph),
    .addr_valid  (addr_valid),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .buf_en      (buf_en),
    .addr_out    (addr_out)
);

// File: tb/bus_strobe_gen_tb.sv
module bus_strobe_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rw = 1'b1;
    logic        kernel_mode = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic        e_ph, q_ph, addr_valid, rd_n, wr_n, buf_en, buf_dir;
    logic [15:0] addr_out;
    logic        s_e, s_q, s_v, s_rd, s_wr, s_en, s_dir;
    logic [3:0]  s_addr;

    int checks = 0;
    int failures = 0;
    int n = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bus_strobe_gen u_dut (
        .clk(clk), .rst_n(rst_n), .rw(rw), .kernel_mode(kernel_mode),
        .cpu_addr(cpu_addr), .e_ph(e_ph), .q_ph(q_ph), .addr_valid(addr_valid),
        .rd_n(rd_n), .wr_n(wr_n), .buf_en(buf_en), .buf_dir(buf_dir),
        .addr_out(addr_out)
    );

    // Narrow instance held in diagnostic mode to reach the wrap quickly.
    bus_strobe_gen #(.ADDR_W(4)) u_small (
        .clk(clk), .rst_n(rst_n), .rw(rw), .kernel_mode(1'b1),
        .cpu_addr(4'h0), .e_ph(s_e), .q_ph(s_q), .addr_valid(s_v),
        .rd_n(s_rd), .wr_n(s_wr), .buf_en(s_en), .buf_dir(s_dir),
        .addr_out(s_addr)
    );

    // Vector: rw, kernel, cpu_addr, rd_n pattern, wr_n pattern, buf_en, buf_dir,
    // addr in cycles 1..3, addr in cycle 4. Pattern bit 3 = cycle 1 .. bit 0 = cycle 4.
    localparam logic [59:0] TBL [6] = '{
        {1'b1, 1'b0, 16'h1234, 4'b0001, 4'b1111, 1'b1, 1'b1, 16'h1234, 16'h1234},
        {1'b0, 1'b0, 16'hBEEF, 4'b1111, 4'b0011, 1'b1, 1'b0, 16'hBEEF, 16'hBEEF},
        {1'b1, 1'b1, 16'h5555, 4'b1111, 4'b1111, 1'b0, 1'b1, 16'h0000, 16'h0001},
        {1'b0, 1'b1, 16'hAAAA, 4'b1111, 4'b1111, 1'b0, 1'b0, 16'h0001, 16'h0002},
        {1'b0, 1'b0, 16'h0000, 4'b1111, 4'b0011, 1'b1, 1'b0, 16'h0000, 16'h0000},
        {1'b1, 1'b0, 16'hFFFF, 4'b0001, 4'b1111, 1'b1, 1'b1, 16'hFFFF, 16'hFFFF}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h (n=%0d)", req, act, exp, n);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        n++;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state, with diagnostic mode on so the sweep must be zero.
        rw = 1'b1;
        kernel_mode = 1'b1;
        repeat (3) step();
        chk("R1 e_ph", e_ph, 0);
        chk("R1 q_ph", q_ph, 0);
        chk("R1 addr_valid", addr_valid, 0);
        chk("R1 rd_n", rd_n, 1);
        chk("R1 wr_n", wr_n, 1);
        chk("R1 sweep", addr_out, 0);

        // Release and walk the vector table, one bus cycle per entry.
        rst_n = 1'b1;
        kernel_mode = 1'b0;
        n = 0;
        for (int i = 0; i < 6; i++) begin
            logic [59:0] v;
            v = TBL[i];
            rw = v[59];
            kernel_mode = v[58];
            cpu_addr = v[57:42];
            for (int p = 1; p <= 4; p++) begin
                step();
                chk("R2 q_ph", q_ph, (p == 1 || p == 2));
                chk("R2 e_ph", e_ph, (p == 2 || p == 3));
                chk("R3 addr_valid", addr_valid, (p != 4));
                chk("R4 R7 rd_n", rd_n, v[41 - (p - 1)]);
                chk("R5 R7 wr_n", wr_n, v[37 - (p - 1)]);
                chk("R6 R7 buf_en", buf_en, v[33]);
                chk("R6 buf_dir", buf_dir, v[32]);
                chk("R8 R9 addr_out", addr_out, (p < 4) ? v[31:16] : v[15:0]);
                chk("R10 strobes", (rd_n || wr_n), 1);
            end
        end

        // R1: reset in the middle of a read cycle.
        step();
        rw = 1'b1;
        kernel_mode = 1'b0;
        rst_n = 1'b0;
        step();
        chk("R1 mid q_ph", q_ph, 0);
        chk("R1 mid e_ph", e_ph, 0);
        chk("R1 mid rd_n", rd_n, 1);
        chk("R1 mid wr_n", wr_n, 1);
        chk("R1 mid sweep small", s_addr, 0);

        // R8: sweep from zero, one step per bus cycle, with wrap in the narrow instance.
        rst_n = 1'b1;
        kernel_mode = 1'b1;
        cpu_addr = 16'h7777;
        n = 0;
        step();
        chk("R2 first edge q_ph", q_ph, 1);
        chk("R2 first edge e_ph", e_ph, 0);
        chk("R8 sweep start", addr_out, 0);
        for (int k = 2; k <= 68; k++) begin
            step();
            if (n % 4 == 0) chk("R8 sweep count", addr_out, n / 4);
            if (n == 60) chk("R8 small top", s_addr, 15);
            if (n == 64) chk("R8 small wrap", s_addr, 0);
            if (n == 68) chk("R8 small after wrap", s_addr, 1);
            chk("R7 kernel rd_n", rd_n, 1);
        end

        // R9: leaving diagnostic mode restores the master address at once.
        kernel_mode = 1'b0;
        #1;
        chk("R9 pass-through", addr_out, 16'h7777);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule